// File: doc/BRIEF.md
# Programmable Flag Port Controller

This block manages a small group of general-purpose flag lines, eight by default. Each line can be an input or an output. An input line can also be an interrupt source, and it can be set to fire either while it sits at its active level or once when it moves into that level. Software configures the lines through a flat register bus with a write strobe and combinational read data. The bus sets direction, output value, input polarity, sensing mode, interrupt enable, wake enable, alternate-function enable and shutdown enable. The same bus reports per-line status and the synchronized pin levels.

Three side outputs serve neighbouring units. A wake signal is formed purely from gates on the raw pins, so a core whose clock is stopped can still be roused. An active-low trip signal goes to a motor-drive PWM generator whenever any line chosen for that duty is active. Lines 7 to 1 can be handed to an SPI engine as slave-select outputs, and line 0 can be handed to it as the slave-select input. Neither the SPI engine nor the PWM generator is part of this block.

Register offsets on `addr`: 0 direction, 1 output data, 2 polarity, 3 edge select, 4 interrupt enable, 5 wake enable, 6 alternate enable, 7 trip enable, 8 status (write 1 to clear), 9 synchronized pin levels. All other offsets read 0. Bit i of each register belongs to line i.

Top module: `flag_port_ctrl`

## Requirements
- R1: After reset every configuration register reads 0, `pad_oe` is 0, `irq` is 0, `trip_n` is 1, `ss_in_n` is 1 and status reads 0.
- R2: Writes to offsets 0 to 7 read back unchanged. A line that is not in alternate use has `pad_oe[i]` equal to direction bit i (1 = output) and `pad_out[i]` equal to output-data bit i.
- R3: Offset 9 returns the pins through a two-flop synchronizer. A pin change made just after a rising edge is still absent after the next edge and is present after the second.
- R4: A line's active level is its synchronized pin XOR its polarity bit, so a polarity bit of 1 makes a low pin active.
- R5: With edge select 0 (level mode), the line's status bit equals its active level and clears by itself when the line goes inactive.
- R6: With edge select 1 (edge mode), an inactive-to-active change sets the status bit. The bit stays set after the line returns inactive. Writing 1 to that bit at offset 8 clears it, and writing 0 has no effect. If a set and a clear fall in the same cycle, the set wins.
- R7: `irq` is high exactly when some line has both its status bit and its interrupt-enable bit at 1.
- R8: `wake` is a purely combinational OR over lines of (raw pin XOR polarity) AND wake enable AND NOT direction. It follows a pin change with no clock edge in between.
- R9: For lines 7 to 1 with alternate enable 1, `pad_oe[i]` is 1 and `pad_out[i]` equals `ss_drive_n[i-1]`, whatever the direction and data bits hold.
- R10: For line 0 with alternate enable 1, `pad_oe[0]` is 0 and `ss_in_n` equals the synchronized pin 0. With alternate enable 0, `ss_in_n` is 1.
- R11: `trip_n` is 0 while any line with trip enable 1 is at its active level, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register offset for reads and writes |
| wdata | input | N | Write data |
| rdata | output | N | Combinational read data for `addr` |
| pad_in | input | N | Raw pin levels |
| pad_out | output | N | Pin output values |
| pad_oe | output | N | Pin output enables |
| ss_drive_n | input | N-1 | Slave-select values from the SPI engine for lines N-1..1 |
| ss_in_n | output | 1 | Slave-select input passed to the SPI engine |
| trip_n | output | 1 | Active-low shutdown request to the PWM generator |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Asynchronous wake request |

## Verification
The flag function is driven with steady levels and with transitions, in both polarities, so level status that tracks the pin can be told apart from edge status that latches. Clear writes of 0 and of 1 against a latched edge bit separate the write-1-to-clear rule from a plain overwrite. Wake is sampled one delta after a pin change, with no edge in between, which exposes any registered path. Alternate enables are combined with conflicting direction and data values to show that the override wins on each side of line 0.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int ADDR_W = 4;
  localparam int NCFG   = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR  = 4'd0,
    A_OUT  = 4'd1,
    A_POL  = 4'd2,
    A_EDGE = 4'd3,
    A_IEN  = 4'd4,
    A_WAKE = 4'd5,
    A_ALT  = 4'd6,
    A_TRIP = 4'd7,
    A_STAT = 4'd8,
    A_PIN  = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/flag_regs.sv
module flag_regs
  import flag_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [N-1:0]                wdata,
  output logic [NCFG-1:0][N-1:0]      cfg
);
  logic [NCFG-1:0][N-1:0] cfg_q;
  logic [NCFG-1:0][N-1:0] cfg_d;
  logic [NCFG-1:0]        cfg_en;

  always_comb begin
    for (int k = 0; k < NCFG; k++) begin
      cfg_en[k] = wr_en && (addr == ADDR_W'(k));
      cfg_d[k]  = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      for (int k = 0; k < NCFG; k++) begin
        if (cfg_en[k]) cfg_q[k] <= cfg_d[k];
      end
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_raw,
  output logic [N-1:0] pin_sync
);
  logic [N-1:0] meta_q, stab_q;
  logic [N-1:0] meta_d, stab_d;

  always_comb begin
    meta_d = pin_raw;
    stab_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
    end
  end

  assign pin_sync = stab_q;
endmodule

// File: rtl/flag_event.sv
module flag_event #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] act,
  input  logic [N-1:0] edge_sel,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] held,
  output logic [N-1:0] status
);
  logic [N-1:0] prev_q, prev_d;
  logic [N-1:0] sticky_q, sticky_d;
  logic [N-1:0] rise, set_v, clr_v;
  logic         sticky_en;

  always_comb begin
    rise      = act & ~prev_q;
    set_v     = rise & edge_sel;
    clr_v     = clr_wr ? clr_mask : '0;
    prev_d    = act;
    sticky_d  = (sticky_q & ~clr_v) | set_v;
    sticky_en = clr_wr | (|set_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      sticky_q <= '0;
    end else begin
      prev_q <= prev_d;
      if (sticky_en) sticky_q <= sticky_d;
    end
  end

  assign held   = sticky_q;
  assign status = (edge_sel & sticky_q) | (~edge_sel & act);
endmodule

// File: rtl/flag_pad_mux.sv
module flag_pad_mux #(
  parameter int N = 8
) (
  input  logic [N-1:0] dir,
  input  logic [N-1:0] dout,
  input  logic [N-1:0] alt,
  input  logic [N-2:0] ss_drive_n,
  input  logic         pin0_sync,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe,
  output logic         ss_in_n
);
  for (genvar i = 0; i < N; i++) begin : g_line
    if (i == 0) begin : g_sel_in
      assign pad_oe[i]  = dir[i] & ~alt[i];
      assign pad_out[i] = dout[i];
    end else begin : g_sel_out
      assign pad_oe[i]  = dir[i] | alt[i];
      assign pad_out[i] = alt[i] ? ss_drive_n[i-1] : dout[i];
    end
  end

  assign ss_in_n = alt[0] ? pin0_sync : 1'b1;
endmodule

// File: rtl/flag_port_ctrl.sv
module flag_port_ctrl
  import flag_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      rdata,
  input  logic [N-1:0]      pad_in,
  output logic [N-1:0]      pad_out,
  output logic [N-1:0]      pad_oe,
  input  logic [N-2:0]      ss_drive_n,
  output logic              ss_in_n,
  output logic              trip_n,
  output logic              irq,
  output logic              wake
);
  logic [1:0]             rst_pipe_q;
  logic                   rst_sync_n;
  logic [NCFG-1:0][N-1:0] cfg;
  logic [N-1:0] dir_q, out_q, pol_q, edge_q, ien_q, wake_q, alt_q, trip_q;
  logic [N-1:0] pin_sync, act, held, status;
  logic         clr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  flag_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .cfg(cfg)
  );

  assign dir_q  = cfg[A_DIR];
  assign out_q  = cfg[A_OUT];
  assign pol_q  = cfg[A_POL];
  assign edge_q = cfg[A_EDGE];
  assign ien_q  = cfg[A_IEN];
  assign wake_q = cfg[A_WAKE];
  assign alt_q  = cfg[A_ALT];
  assign trip_q = cfg[A_TRIP];

  flag_sync #(.N(N)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .pin_raw(pad_in), .pin_sync(pin_sync)
  );

  assign act    = pin_sync ^ pol_q;
  assign clr_wr = wr_en && (addr == A_STAT);

  flag_event #(.N(N)) u_event (
    .clk(clk), .rst_n(rst_sync_n), .act(act), .edge_sel(edge_q),
    .clr_wr(clr_wr), .clr_mask(wdata), .held(held), .status(status)
  );

  flag_pad_mux #(.N(N)) u_mux (
    .dir(dir_q), .dout(out_q), .alt(alt_q), .ss_drive_n(ss_drive_n),
    .pin0_sync(pin_sync[0]), .pad_out(pad_out), .pad_oe(pad_oe),
    .ss_in_n(ss_in_n)
  );

  assign irq    = |(status & ien_q);
  assign trip_n = ~|(act & trip_q);
  assign wake   = |((pad_in ^ pol_q) & wake_q & ~dir_q);

  always_comb begin
    rdata = '0;
    if (addr < ADDR_W'(NCFG)) rdata = cfg[addr[2:0]];
    else if (addr == A_STAT)  rdata = status;
    else if (addr == A_PIN)   rdata = pin_sync;
  end
endmodule

// File: rtl/flag_port_chk.sv
module flag_port_chk
  import flag_pkg::*;
#(
  parameter int N = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N-1:0]      ien_q,
  input logic [N-1:0]      wake_q,
  input logic [N-1:0]      alt_q,
  input logic [N-1:0]      trip_q,
  input logic [N-1:0]      held,
  input logic [N-1:0]      pad_oe,
  input logic              irq,
  input logic              wake,
  input logic              trip_n
);
  assert_sticky_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_STAT) |=> (($past(held) & ~held) == '0));

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  assert_wake_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q == '0) |-> !wake);

  assert_sel_out_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((alt_q[N-1:1] & ~pad_oe[N-1:1]) == '0));

  assert_sel_in_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alt_q[0] |-> !pad_oe[0]);

  assert_trip_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q == '0) |-> trip_n);
endmodule

bind flag_port_ctrl flag_port_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr),
  .ien_q(ien_q), .wake_q(wake_q), .alt_q(alt_q), .trip_q(trip_q),
  .held(held), .pad_oe(pad_oe), .irq(irq), .wake(wake), .trip_n(trip_n)
);

// File: tb/sim_flag_port_ctrl.sv
`timescale 1ns/1ps
module sim_flag_port_ctrl;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] addr;
  logic [7:0] wdata, rdata, pad_in, pad_out, pad_oe;
  logic [6:0] ss_drive_n;
  logic       ss_in_n, trip_n, irq, wake;

  int checks = 0;
  int errors = 0;

  localparam int K_RD = 0, K_OE = 1, K_OUT = 2, K_IRQ = 3, K_TRIP = 4, K_SSIN = 5;

  int         kq[$];
  logic [7:0] eq[$];
  string      tq[$];

  flag_port_ctrl #(.N(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .ss_drive_n(ss_drive_n), .ss_in_n(ss_in_n), .trip_n(trip_n),
    .irq(irq), .wake(wake)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: pops expected items and compares them with the outputs
  int         mk;
  logic [7:0] mexp, mact;
  string      mtag;
  always @(negedge clk) begin
    if (kq.size() > 0) begin
      mk   = kq.pop_front();
      mexp = eq.pop_front();
      mtag = tq.pop_front();
      case (mk)
        K_RD:    mact = rdata;
        K_OE:    mact = pad_oe;
        K_OUT:   mact = pad_out;
        K_IRQ:   mact = {7'b0, irq};
        K_TRIP:  mact = {7'b0, trip_n};
        default: mact = {7'b0, ss_in_n};
      endcase
      checks++;
      if (mact !== mexp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", mtag, mact, mexp);
      end
    end
  end

  task automatic chk(input int kind, input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    addr = a;
    kq.push_back(kind); eq.push_back(exp); tq.push_back(tag);
    @(negedge clk); #1;
  endtask

  task automatic dchk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic setpad(input logic [7:0] v);
    @(posedge clk); #1;
    pad_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 4'd0; wdata = 8'h00;
    pad_in = 8'h00; ss_drive_n = 7'h55;
    idle(3);
    #1 rst_n = 1'b1;
    idle(3);

    // R1 reset state
    chk(K_RD, 4'd0, 8'h00, "R1 direction reg");
    chk(K_RD, 4'd7, 8'h00, "R1 trip reg");
    chk(K_OE, 4'd0, 8'h00, "R1 pad_oe");
    chk(K_IRQ, 4'd0, 8'h00, "R1 irq");
    chk(K_TRIP, 4'd0, 8'h01, "R1 trip_n");
    chk(K_SSIN, 4'd0, 8'h01, "R1 ss_in_n");
    chk(K_RD, 4'd8, 8'h00, "R1 status");

    // R2 plain output
    wr(4'd0, 8'hF0);
    wr(4'd1, 8'hA5);
    chk(K_OE, 4'd0, 8'hF0, "R2 pad_oe from direction");
    chk(K_OUT, 4'd0, 8'hA5, "R2 pad_out from data");
    chk(K_RD, 4'd1, 8'hA5, "R2 readback");
    wr(4'd0, 8'h00);

    // R3 two-flop synchronizer latency
    setpad(8'h3C);
    chk(K_RD, 4'd9, 8'h00, "R3 after one edge");
    chk(K_RD, 4'd9, 8'h3C, "R3 after two edges");

    // R4 / R5 polarity and level status
    wr(4'd2, 8'h01);
    chk(K_RD, 4'd8, 8'h3D, "R4 R5 level with inverted line 0");
    setpad(8'h00);
    idle(3);
    chk(K_RD, 4'd8, 8'h01, "R4 low pin active when inverted");
    wr(4'd2, 8'h00);
    chk(K_RD, 4'd8, 8'h00, "R5 level status clears");

    // R6 / R7 edge status
    wr(4'd3, 8'h02);
    wr(4'd4, 8'h02);
    chk(K_RD, 4'd8, 8'h00, "R6 no edge yet");
    setpad(8'h02);
    idle(4);
    chk(K_RD, 4'd8, 8'h02, "R6 edge latched");
    chk(K_IRQ, 4'd8, 8'h01, "R7 irq on enabled status");
    setpad(8'h00);
    idle(4);
    chk(K_RD, 4'd8, 8'h02, "R6 sticky after release");
    wr(4'd8, 8'h00);
    chk(K_RD, 4'd8, 8'h02, "R6 write of zero ignored");
    wr(4'd8, 8'h02);
    chk(K_RD, 4'd8, 8'h00, "R6 write one clears");
    chk(K_IRQ, 4'd8, 8'h00, "R7 irq drops after clear");
    setpad(8'h04);
    idle(3);
    chk(K_RD, 4'd8, 8'h04, "R5 level line active");
    chk(K_IRQ, 4'd8, 8'h00, "R7 unenabled line gives no irq");
    setpad(8'h00);
    idle(3);
    wr(4'd4, 8'h00);
    wr(4'd3, 8'h00);

    // R8 asynchronous wake
    wr(4'd5, 8'h08);
    #1 dchk(wake, 1'b0, "R8 wake idle");
    @(posedge clk); #2;
    pad_in = 8'h08;
    #1 dchk(wake, 1'b1, "R8 wake without clock edge");
    wr(4'd0, 8'h08);
    #1 dchk(wake, 1'b0, "R8 output line cannot wake");
    wr(4'd0, 8'h00);
    pad_in = 8'h00;
    #1 dchk(wake, 1'b0, "R8 wake follows pin low");
    wr(4'd2, 8'h08);
    #1 dchk(wake, 1'b1, "R8 inverted low pin wakes");
    wr(4'd2, 8'h00);
    wr(4'd5, 8'h00);

    // R9 / R10 alternate functions
    wr(4'd1, 8'h00);
    wr(4'd6, 8'hFF);
    chk(K_OE, 4'd0, 8'hFE, "R9 R10 alternate enables");
    chk(K_OUT, 4'd0, 8'hAA, "R9 select outputs from engine");
    idle(3);
    chk(K_SSIN, 4'd0, 8'h00, "R10 select input low");
    setpad(8'h01);
    idle(3);
    chk(K_SSIN, 4'd0, 8'h01, "R10 select input high");
    wr(4'd0, 8'hFF);
    wr(4'd1, 8'hFF);
    chk(K_OE, 4'd0, 8'hFE, "R10 line 0 input despite direction");
    chk(K_OUT, 4'd0, 8'hAB, "R9 override of data");
    setpad(8'h00);
    wr(4'd6, 8'h00);
    chk(K_OE, 4'd0, 8'hFF, "R2 direction back in control");
    chk(K_SSIN, 4'd0, 8'h01, "R10 select input idle when disabled");
    wr(4'd0, 8'h00);
    wr(4'd1, 8'h00);

    // R11 PWM trip
    wr(4'd7, 8'h10);
    idle(3);
    chk(K_TRIP, 4'd0, 8'h01, "R11 no trip while inactive");
    setpad(8'h10);
    idle(3);
    chk(K_TRIP, 4'd0, 8'h00, "R11 trip on active line");
    wr(4'd2, 8'h10);
    chk(K_TRIP, 4'd0, 8'h01, "R11 trip released by polarity");
    setpad(8'h20);
    idle(3);
    chk(K_TRIP, 4'd0, 8'h00, "R11 inverted low pin trips");
    wr(4'd7, 8'h00);

    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule